// File: doc/BRIEF.md
# Double-Precision Float to Integer Converter

This unit turns a 64-bit IEEE-754 binary64 operand into a signed or unsigned integer of either 32 or 64 bits. Each conversion is requested for one cycle with `inValid`, and its result appears one clock later with `outValid`. A 3-bit operation select picks the target signedness and width, and chooses whether rounding follows the 2-bit rounding-mode input or is forced to truncation.

Next to the integer, the unit reports four status bits. An invalid-conversion flag marks a NaN, an infinity or an out-of-range value. A separate flag marks a signaling NaN. An inexact flag marks a valid conversion that dropped a nonzero fraction. A summary bit is raised whenever this conversion raised any of those flags. The surrounding pipeline decides what to do with those bits. Invalid inputs still produce a defined integer: either the saturated limit of the target type or a fixed NaN substitute.

Top module: `dbl_to_int_cvt`

## Requirements
- R1: `opSel` decodes as follows. Bit 2 set selects an unsigned target. Bit 1 set selects a 64-bit target, and clear selects a 32-bit target. Bit 0 set forces truncation and ignores `rndMode`. All eight combinations are legal. A request with `inValid` high is answered on the next clock edge, with `outValid` high for exactly that one cycle.
- R2: `rndMode` selects the rounding of non-truncating operations: 00 is nearest with ties to even, 01 is toward zero, 10 is toward +infinity and 11 is toward -infinity.
- R3: A NaN operand of either sign and either kind sets the invalid-conversion flag. The result is then 0x80000000 for a signed 32-bit target, 0x8000000000000000 for a signed 64-bit target, and zero for either unsigned target.
- R4: A signaling NaN (exponent all ones, fraction nonzero, fraction MSB bit 51 clear) also sets the signaling-NaN flag. A quiet NaN leaves that flag clear.
- R5: An infinity, or a finite value whose rounded magnitude does not fit the target, sets only the invalid-conversion flag. The result saturates to the target maximum for positive values, and to the signed minimum for negative values on signed targets.
- R6: On an unsigned target, a negative operand that rounds to zero gives 0 and is valid. A negative operand that rounds to a nonzero magnitude is invalid and gives 0.
- R7: The inexact flag is set exactly when a valid conversion discards a nonzero fraction, including subnormal operands. It is never set together with the invalid-conversion flag. Negative zero converts to 0 with no flags.
- R8: The summary flag is high exactly when the invalid-conversion, signaling-NaN or inexact flag is high for the same conversion. It falls again on the next conversion that raises none of them.
- R9: For 32-bit targets the integer sits in result bits 31:0 in two's complement, and bits 63:32 are zero.
- R10: After reset, `outValid`, `result` and all flags are zero. While `inValid` is low, `result` and the flags keep their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Conversion request for this cycle |
| operand | input | 64 | binary64 operand |
| opSel | input | 3 | {unsigned, 64-bit, truncate} |
| rndMode | input | 2 | Rounding mode for non-truncating operations |
| outValid | output | 1 | Result and flags belong to a new conversion |
| result | output | 64 | Converted integer |
| flagInvalidCvt | output | 1 | Invalid conversion (NaN, infinity, out of range) |
| flagInvalidSnan | output | 1 | Operand was a signaling NaN |
| flagInexact | output | 1 | Nonzero fraction discarded |
| flagSummary | output | 1 | Any flag raised by this conversion |

## Verification
The unit holds one register stage, so any wrong internal decision appears at the ports one cycle after the request and nowhere else. A misplaced alignment shift or a wrong rounding increment shows up as an integer off by a power of two or by one. A wrong range limit shows up as a missing saturation, or as a false invalid flag on values exactly at a type boundary. A wrong target decode shows up as nonzero upper bits on a 32-bit target, or as the wrong NaN substitute. A stuck load strobe shows up as results changing while no request is present.

// File: rtl/dti_pkg.sv
package dti_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_ZERO      = 2'b01,
    RND_POS       = 2'b10,
    RND_NEG       = 2'b11
  } rnd_e;

  typedef enum logic [1:0] {
    CLS_FINITE = 2'b00,
    CLS_INF    = 2'b01,
    CLS_QNAN   = 2'b10,
    CLS_SNAN   = 2'b11
  } cls_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic isUnsigned;
    logic isDword;
    rnd_e mode;
  } cvtCtrl_t;

  // opSel bit positions
  localparam int OP_TRUNC_BIT = 0;
  localparam int OP_DWORD_BIT = 1;
  localparam int OP_UNS_BIT   = 2;

endpackage

// File: rtl/dti_unpack.sv
module dti_unpack
  import dti_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64
) (
  input  logic [EXP_W+FRAC_W:0] operand,
  output logic                  signBit,
  output cls_e                  cls,
  output logic                  preOverflow,
  output logic [INT_W-1:0]      intMag,
  output logic                  roundBit,
  output logic                  stickyBit
);

  localparam int MAN_W  = FRAC_W + 1;
  localparam int FIX_W  = 2 * INT_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int SH_OFF = INT_W - FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic [MAN_W-1:0]  mant;
  logic [FIX_W-1:0]  fixedVal;
  int                effExp;
  int                unbExp;
  int                shAmt;

  assign signBit   = operand[EXP_W+FRAC_W];
  assign expField  = operand[EXP_W+FRAC_W-1:FRAC_W];
  assign fracField = operand[FRAC_W-1:0];
  assign mant      = {(expField != '0), fracField};

  always_comb begin
    if (expField != '1)       cls = CLS_FINITE;
    else if (fracField == '0) cls = CLS_INF;
    else if (fracField[FRAC_W-1]) cls = CLS_QNAN;
    else                      cls = CLS_SNAN;
  end

  // place the mantissa on a fixed point grid with INT_W integer bits
  always_comb begin
    effExp      = (expField == '0) ? 1 : int'(expField);
    unbExp      = effExp - BIAS;
    preOverflow = (unbExp >= INT_W);
    shAmt       = 0;
    fixedVal    = '0;
    if (unbExp <= -2) begin
      intMag    = '0;
      roundBit  = 1'b0;
      stickyBit = |mant;
    end else begin
      shAmt     = unbExp + SH_OFF;
      fixedVal  = FIX_W'(mant) << shAmt;
      intMag    = fixedVal[FIX_W-1:INT_W];
      roundBit  = fixedVal[INT_W-1];
      stickyBit = |fixedVal[INT_W-2:0];
    end
  end

endmodule

// File: rtl/dti_ctrl.sv
module dti_ctrl
  import dti_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic [2:0] opSel,
  input  logic [1:0] rndMode,
  output cvtCtrl_t strobe,
  output logic     outValid
);

  always_comb begin
    strobe.load       = inValid;
    strobe.isUnsigned = opSel[OP_UNS_BIT];
    strobe.isDword    = opSel[OP_DWORD_BIT];
    strobe.mode       = opSel[OP_TRUNC_BIT] ? RND_ZERO : rnd_e'(rndMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/dti_datapath.sv
module dti_datapath
  import dti_pkg::*;
#(
  parameter int INT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cvtCtrl_t         strobe,
  input  logic             signBit,
  input  cls_e             cls,
  input  logic             preOverflow,
  input  logic [INT_W-1:0] intMag,
  input  logic             roundBit,
  input  logic             stickyBit,
  output logic [INT_W-1:0] result,
  output logic             flagInvalidCvt,
  output logic             flagInvalidSnan,
  output logic             flagInexact,
  output logic             flagSummary
);

  localparam int NUM_TGT = 4;
  localparam logic [INT_W:0] ONE = (INT_W+1)'(1);

  logic [INT_W:0]   posLim [NUM_TGT];
  logic [INT_W:0]   negLim [NUM_TGT];
  logic [INT_W-1:0] satPos [NUM_TGT];
  logic [INT_W-1:0] satNeg [NUM_TGT];

  // per target limits, index = {unsigned, dword}
  for (genvar k = 0; k < NUM_TGT; k++) begin : g_target
    localparam bit UNS = ((k / 2) == 1);
    localparam bit DW  = ((k % 2) == 1);
    localparam int TW  = DW ? INT_W : WORD_W;
    assign posLim[k] = UNS ? ((ONE << TW) - ONE) : ((ONE << (TW - 1)) - ONE);
    assign negLim[k] = UNS ? '0 : (ONE << (TW - 1));
    assign satPos[k] = posLim[k][INT_W-1:0];
    assign satNeg[k] = negLim[k][INT_W-1:0];
  end

  logic [1:0]       tgt;
  logic             lostFrac;
  logic             incr;
  logic [INT_W:0]   magR;
  logic             rangeBad;
  logic [INT_W-1:0] wordMask;
  logic [INT_W-1:0] signedVal;
  logic [INT_W-1:0] nxtResult;
  logic             nxtCvt, nxtSnan, nxtInexact;

  assign tgt      = {strobe.isUnsigned, strobe.isDword};
  assign lostFrac = roundBit | stickyBit;
  assign wordMask = strobe.isDword ? '1 : INT_W'({WORD_W{1'b1}});

  always_comb begin
    unique case (strobe.mode)
      RND_NEAR_EVEN: incr = roundBit & (stickyBit | intMag[0]);
      RND_ZERO:      incr = 1'b0;
      RND_POS:       incr = ~signBit & lostFrac;
      RND_NEG:       incr = signBit & lostFrac;
      default:       incr = 1'b0;
    endcase
  end

  assign magR = {1'b0, intMag} + (INT_W+1)'(incr);

  always_comb begin
    if (preOverflow)  rangeBad = 1'b1;
    else if (signBit) rangeBad = (magR > negLim[tgt]);
    else              rangeBad = (magR > posLim[tgt]);
  end

  assign signedVal = signBit ? (INT_W'(0) - magR[INT_W-1:0]) : magR[INT_W-1:0];

  always_comb begin
    nxtResult  = '0;
    nxtCvt     = 1'b0;
    nxtSnan    = 1'b0;
    nxtInexact = 1'b0;
    unique case (cls)
      CLS_QNAN, CLS_SNAN: begin
        nxtResult = satNeg[tgt];
        nxtCvt    = 1'b1;
        nxtSnan   = (cls == CLS_SNAN);
      end
      CLS_INF: begin
        nxtResult = signBit ? satNeg[tgt] : satPos[tgt];
        nxtCvt    = 1'b1;
      end
      default: begin
        if (rangeBad) begin
          nxtResult = signBit ? satNeg[tgt] : satPos[tgt];
          nxtCvt    = 1'b1;
        end else begin
          nxtResult  = signedVal & wordMask;
          nxtInexact = lostFrac;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result          <= '0;
      flagInvalidCvt  <= 1'b0;
      flagInvalidSnan <= 1'b0;
      flagInexact     <= 1'b0;
      flagSummary     <= 1'b0;
    end else if (strobe.load) begin
      result          <= nxtResult;
      flagInvalidCvt  <= nxtCvt;
      flagInvalidSnan <= nxtSnan;
      flagInexact     <= nxtInexact;
      flagSummary     <= nxtCvt | nxtSnan | nxtInexact;
    end
  end

endmodule

// File: rtl/dbl_to_int_cvt.sv
module dbl_to_int_cvt
  import dti_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] operand,
  input  logic [2:0]            opSel,
  input  logic [1:0]            rndMode,
  output logic                  outValid,
  output logic [INT_W-1:0]      result,
  output logic                  flagInvalidCvt,
  output logic                  flagInvalidSnan,
  output logic                  flagInexact,
  output logic                  flagSummary
);

  cvtCtrl_t         strobe;
  logic             signBit;
  cls_e             cls;
  logic             preOverflow;
  logic [INT_W-1:0] intMag;
  logic             roundBit;
  logic             stickyBit;

  dti_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opSel    (opSel),
    .rndMode  (rndMode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  dti_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_unpack (
    .operand     (operand),
    .signBit     (signBit),
    .cls         (cls),
    .preOverflow (preOverflow),
    .intMag      (intMag),
    .roundBit    (roundBit),
    .stickyBit   (stickyBit)
  );

  dti_datapath #(.INT_W(INT_W), .WORD_W(WORD_W)) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .signBit         (signBit),
    .cls             (cls),
    .preOverflow     (preOverflow),
    .intMag          (intMag),
    .roundBit        (roundBit),
    .stickyBit       (stickyBit),
    .result          (result),
    .flagInvalidCvt  (flagInvalidCvt),
    .flagInvalidSnan (flagInvalidSnan),
    .flagInexact     (flagInexact),
    .flagSummary     (flagSummary)
  );

endmodule

// File: rtl/dti_checker.sv
module dti_checker #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 64,
  parameter int WORD_W = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic [EXP_W+FRAC_W-1:0] expFrac,
  input logic [2:0]              opSel,
  input logic                    outValid,
  input logic [INT_W-1:0]        result,
  input logic                    flagInvalidCvt,
  input logic                    flagInvalidSnan,
  input logic                    flagInexact,
  input logic                    flagSummary
);

  localparam logic [INT_W-1:0] WORD_MIN  = INT_W'(1) << (WORD_W - 1);
  localparam logic [INT_W-1:0] DWORD_MIN = INT_W'(1) << (INT_W - 1);

  logic nanIn;
  assign nanIn = (&expFrac[EXP_W+FRAC_W-1:FRAC_W]) && (|expFrac[FRAC_W-1:0]);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  p_nan_value_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(nanIn)) |->
      (flagInvalidCvt &&
       result == ($past(opSel[2]) ? '0 : ($past(opSel[1]) ? DWORD_MIN : WORD_MIN))));

  p_snan_implies_cvt_r4: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalidSnan |-> flagInvalidCvt);

  p_no_inexact_when_invalid_r7: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalidCvt |-> !flagInexact);

  p_summary_r8: assert property (@(posedge clk) disable iff (!rstN)
    flagSummary == (flagInvalidCvt || flagInvalidSnan || flagInexact));

  p_word_upper_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(opSel[1])) |-> (result[INT_W-1:WORD_W] == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(flagSummary)));

endmodule

bind dbl_to_int_cvt dti_checker #(
  .EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W), .WORD_W(WORD_W)
) u_dtiChecker (
  .clk             (clk),
  .rstN            (rstN),
  .inValid         (inValid),
  .expFrac         (operand[EXP_W+FRAC_W-1:0]),
  .opSel           (opSel),
  .outValid        (outValid),
  .result          (result),
  .flagInvalidCvt  (flagInvalidCvt),
  .flagInvalidSnan (flagInvalidSnan),
  .flagInexact     (flagInexact),
  .flagSummary     (flagSummary)
);

// File: tb/tb_dbl_to_int_cvt.sv
module tb_dbl_to_int_cvt;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] operand = '0;
  logic [2:0]  opSel = '0;
  logic [1:0]  rndMode = '0;
  logic        outValid;
  logic [63:0] result;
  logic        flagInvalidCvt, flagInvalidSnan, flagInexact, flagSummary;

  int nVec = 0;
  int nMiss = 0;

  always #5 clk = ~clk;

  dbl_to_int_cvt dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .operand(operand),
    .opSel(opSel), .rndMode(rndMode), .outValid(outValid), .result(result),
    .flagInvalidCvt(flagInvalidCvt), .flagInvalidSnan(flagInvalidSnan),
    .flagInexact(flagInexact), .flagSummary(flagSummary)
  );

  // op codes: 0 SW, 1 SW trunc, 2 SD, 3 SD trunc, 4 UW, 5 UW trunc, 6 UD, 7 UD trunc
  // flags: {cvt, snan, inexact, summary}
  localparam int NV = 44;
  localparam logic [152:0] VECS [NV] = '{
    {"R1", 3'd2, 2'd0, 64'h3FF0000000000000, 64'h0000000000000001, 4'b0000},
    {"R2", 3'd0, 2'd0, 64'h3FF8000000000000, 64'h0000000000000002, 4'b0011},
    {"R2", 3'd0, 2'd0, 64'h4004000000000000, 64'h0000000000000002, 4'b0011},
    {"R2", 3'd0, 2'd0, 64'hC004000000000000, 64'h00000000FFFFFFFE, 4'b0011},
    {"R2", 3'd0, 2'd2, 64'h3FF8000000000000, 64'h0000000000000002, 4'b0011},
    {"R2", 3'd0, 2'd2, 64'hBFF8000000000000, 64'h00000000FFFFFFFF, 4'b0011},
    {"R2", 3'd0, 2'd3, 64'h3FF8000000000000, 64'h0000000000000001, 4'b0011},
    {"R2", 3'd0, 2'd3, 64'hBFF8000000000000, 64'h00000000FFFFFFFE, 4'b0011},
    {"R2", 3'd0, 2'd1, 64'hBFF8000000000000, 64'h00000000FFFFFFFF, 4'b0011},
    {"R1", 3'd1, 2'd2, 64'h3FF8000000000000, 64'h0000000000000001, 4'b0011},
    {"R1", 3'd3, 2'd3, 64'hBFF8000000000000, 64'hFFFFFFFFFFFFFFFF, 4'b0011},
    {"R1", 3'd3, 2'd0, 64'h400E000000000000, 64'h0000000000000003, 4'b0011},
    {"R2", 3'd2, 2'd0, 64'h400E000000000000, 64'h0000000000000004, 4'b0011},
    {"R2", 3'd6, 2'd3, 64'h400E000000000000, 64'h0000000000000003, 4'b0011},
    {"R2", 3'd2, 2'd0, 64'h3FE0000000000000, 64'h0000000000000000, 4'b0011},
    {"R7", 3'd2, 2'd2, 64'h0000000000000001, 64'h0000000000000001, 4'b0011},
    {"R7", 3'd2, 2'd0, 64'h0000000000000001, 64'h0000000000000000, 4'b0011},
    {"R7", 3'd2, 2'd0, 64'h8000000000000000, 64'h0000000000000000, 4'b0000},
    {"R5", 3'd2, 2'd0, 64'h43E0000000000000, 64'h7FFFFFFFFFFFFFFF, 4'b1001},
    {"R5", 3'd2, 2'd0, 64'hC3E0000000000000, 64'h8000000000000000, 4'b0000},
    {"R5", 3'd0, 2'd0, 64'h41E0000000000000, 64'h000000007FFFFFFF, 4'b1001},
    {"R5", 3'd0, 2'd0, 64'hC1E0000000000000, 64'h0000000080000000, 4'b0000},
    {"R5", 3'd0, 2'd0, 64'h41DFFFFFFFC00000, 64'h000000007FFFFFFF, 4'b0000},
    {"R5", 3'd4, 2'd0, 64'h41EFFFFFFFE00000, 64'h00000000FFFFFFFF, 4'b0000},
    {"R5", 3'd4, 2'd0, 64'h41F0000000000000, 64'h00000000FFFFFFFF, 4'b1001},
    {"R5", 3'd6, 2'd0, 64'h43F0000000000000, 64'hFFFFFFFFFFFFFFFF, 4'b1001},
    {"R5", 3'd6, 2'd0, 64'h43E0000000000000, 64'h8000000000000000, 4'b0000},
    {"R6", 3'd4, 2'd0, 64'hBFF8000000000000, 64'h0000000000000000, 4'b1001},
    {"R6", 3'd5, 2'd0, 64'hBFD3333333333333, 64'h0000000000000000, 4'b0011},
    {"R6", 3'd4, 2'd0, 64'hBFD3333333333333, 64'h0000000000000000, 4'b0011},
    {"R6", 3'd4, 2'd3, 64'hBFD3333333333333, 64'h0000000000000000, 4'b1001},
    {"R3", 3'd0, 2'd0, 64'h7FF8000000000000, 64'h0000000080000000, 4'b1001},
    {"R4", 3'd0, 2'd0, 64'h7FF0000000000001, 64'h0000000080000000, 4'b1101},
    {"R3", 3'd2, 2'd0, 64'h7FF8000000000000, 64'h8000000000000000, 4'b1001},
    {"R4", 3'd6, 2'd0, 64'h7FF0000000000001, 64'h0000000000000000, 4'b1101},
    {"R3", 3'd5, 2'd0, 64'h7FF8000000000000, 64'h0000000000000000, 4'b1001},
    {"R3", 3'd2, 2'd0, 64'hFFF8000000000000, 64'h8000000000000000, 4'b1001},
    {"R5", 3'd2, 2'd0, 64'h7FF0000000000000, 64'h7FFFFFFFFFFFFFFF, 4'b1001},
    {"R5", 3'd2, 2'd0, 64'hFFF0000000000000, 64'h8000000000000000, 4'b1001},
    {"R5", 3'd6, 2'd0, 64'hFFF0000000000000, 64'h0000000000000000, 4'b1001},
    {"R5", 3'd1, 2'd0, 64'hFFF0000000000000, 64'h0000000080000000, 4'b1001},
    {"R8", 3'd2, 2'd0, 64'h3FF0000000000000, 64'h0000000000000001, 4'b0000},
    {"R9", 3'd0, 2'd0, 64'hBFF0000000000000, 64'h00000000FFFFFFFF, 4'b0000},
    {"R9", 3'd4, 2'd0, 64'h41E0000000000000, 64'h0000000080000000, 4'b0000}
  };

  function automatic logic [3:0] flagsNow();
    return {flagInvalidCvt, flagInvalidSnan, flagInexact, flagSummary};
  endfunction

  task automatic runVec(input logic [152:0] v, input int idx);
    logic [15:0] tag;
    logic [63:0] expRes;
    logic [3:0]  expFlg;
    tag    = v[152:137];
    expRes = v[67:4];
    expFlg = v[3:0];
    @(negedge clk);
    opSel   = v[136:134];
    rndMode = v[133:132];
    operand = v[131:68];
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    nVec++;
    if (!outValid || result !== expRes || flagsNow() !== expFlg) begin
      nMiss++;
      $display("FAIL %s vec %0d: valid=%b result=%h flags=%b, expected valid=1 result=%h flags=%b",
               tag, idx, outValid, result, flagsNow(), expRes, expFlg);
    end
  endtask

  task automatic checkState(input string req, input logic expValid,
                            input logic [63:0] expRes, input logic [3:0] expFlg);
    nVec++;
    if (outValid !== expValid || result !== expRes || flagsNow() !== expFlg) begin
      nMiss++;
      $display("FAIL %s: valid=%b result=%h flags=%b, expected valid=%b result=%h flags=%b",
               req, outValid, result, flagsNow(), expValid, expRes, expFlg);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nMiss++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    checkState("R10 reset", 1'b0, 64'h0, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R10 after release", 1'b0, 64'h0, 4'b0000);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R10: hold while no request, R1: single-cycle valid
    runVec({"R4", 3'd0, 2'd0, 64'h7FF0000000000001, 64'h0000000080000000, 4'b1101}, NV);
    @(negedge clk);
    operand = 64'h3FF0000000000000;
    opSel   = 3'd6;
    rndMode = 2'd2;
    checkState("R1 valid drops", 1'b0, 64'h0000000080000000, 4'b1101);
    @(negedge clk);
    operand = 64'h400E000000000000;
    checkState("R10 hold", 1'b0, 64'h0000000080000000, 4'b1101);
    @(negedge clk);
    checkState("R10 hold again", 1'b0, 64'h0000000080000000, 4'b1101);

    // R1: back-to-back requests each answered one cycle later
    @(negedge clk);
    opSel = 3'd2; rndMode = 2'd0; operand = 64'h3FF0000000000000; inValid = 1'b1;
    @(negedge clk);
    checkState("R1 back-to-back first", 1'b1, 64'h1, 4'b0000);
    opSel = 3'd3; operand = 64'h400E000000000000;
    @(negedge clk);
    inValid = 1'b0;
    checkState("R1 back-to-back second", 1'b1, 64'h3, 4'b0011);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end

endmodule